// File: doc/BRIEF.md
# Byte-Serial Packet Bridge

This block joins an 8-bit byte stream to a wide request/acknowledge packet fabric, in both directions. Inbound bytes arrive on a valid/ready port and are shifted into an accumulator. Each new byte enters at the bottom and the older contents move up one byte. After a fixed number of bytes, the assembled word is copied into a launch register and offered to the fabric with a four-phase producer handshake. The destination field is cut out of the assembled word, and the token flag is always driven clear. No further byte is taken until that handshake has fully returned to idle.

Outbound, the fabric presents one wide word under a four-phase request. The block plays it out as bytes on a valid/ready port, least-significant byte first, by shifting the word right by eight times the byte index. After the last byte it raises the acknowledge, and it drops the acknowledge once the fabric withdraws its request.

The bytes per packet and the position and width of the destination field are parameters. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `byte_packet_bridge`

## Requirements
- R1: While `rst_n` is low (asserted asynchronously) and after its release, `in_ready`=1, `pkt_req`=0, `word_ack`=0, `out_valid`=0 (with `word_req` low) and `pkt_data`=0.
- R2: After six accepted bytes (default `BYTES_PER_PKT`=6), `pkt_data` equals the bytes concatenated with the first accepted byte in bits [47:40] and the last in bits [7:0]: each byte shifts the accumulator left by 8 and fills the low byte.
- R3: `pkt_req` rises in the cycle after the clock edge that accepts the last byte of a packet, never earlier, and `in_ready` falls in that same cycle.
- R4: `pkt_dest` equals `pkt_data[DEST_LSB+DEST_W-1:DEST_LSB]` (default bits [47:40]), and `pkt_token` is 0.
- R5: `pkt_req` and `pkt_data` stay unchanged while `pkt_ack` is low. `pkt_req` falls in the cycle after `pkt_ack` is seen high. `in_ready` returns in the cycle after `pkt_ack` is seen low again.
- R6: From launch until the handshake ends, `in_ready` is 0. A byte offered in that window is not taken and does not count toward the next packet.
- R7: Outbound byte k (k = 0 first) is `word_data[8k+7:8k]`. `out_valid` is high while `word_req` is high and the word is not yet acknowledged.
- R8: `word_ack` rises in the cycle after the edge that accepts the last outbound byte, and `out_valid` stays low while `word_ack` is high. `word_ack` falls in the cycle after `word_req` is seen low.
- R9: While `out_ready` is low, `out_valid` and `out_data` hold and no byte is consumed.
- R10: Every new outbound word starts again at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound byte offered |
| in_data | input | 8 | Inbound byte |
| in_ready | output | 1 | Inbound byte can be taken |
| pkt_req | output | 1 | Fabric packet request (four-phase) |
| pkt_ack | input | 1 | Fabric packet acknowledge |
| pkt_token | output | 1 | Token flag of the launched packet, always 0 |
| pkt_dest | output | DEST_W (8) | Destination field cut from the packet |
| pkt_data | output | 8*BYTES_PER_PKT (48) | Launched packet word |
| word_req | input | 1 | Fabric word request (four-phase) |
| word_ack | output | 1 | Fabric word acknowledge |
| word_data | input | 8*BYTES_PER_PKT (48) | Fabric word to serialise |
| out_valid | output | 1 | Outbound byte offered |
| out_ready | input | 1 | Outbound byte taken |
| out_data | output | 8 | Outbound byte |

## Verification
The bench checks that the first byte lands at the top of the packet. A reversed shift would put it at the bottom and give the wrong destination field. It pushes bytes while a packet is still waiting for its acknowledge. A bridge that took them would launch the following packet early, so the bench checks that the request is still low after five further bytes. It stalls the outbound consumer in the middle of a word, where a design that advanced its index anyway would skip a byte. It also times both handshake returns to the cycle, since a late or early acknowledge edge breaks the four-phase protocol.

// File: rtl/bpb_pkg.sv
`timescale 1ns/1ps
package bpb_pkg;
  typedef enum logic [1:0] {
    IG_FILL = 2'd0,
    IG_REQ  = 2'd1,
    IG_DROP = 2'd2
  } ig_state_e;

  typedef enum logic {
    EG_SEND = 1'b0,
    EG_HOLD = 1'b1
  } eg_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bpb_reset_sync.sv
`timescale 1ns/1ps
module bpb_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bpb_beat_counter.sv
`timescale 1ns/1ps
module bpb_beat_counter #(
  parameter  int unsigned COUNT = 6,
  localparam int unsigned CW    = bpb_pkg::cnt_width(COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          at_last
);
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (at_last) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/bpb_ingress.sv
`timescale 1ns/1ps
module bpb_ingress #(
  parameter  int unsigned BYTES    = 6,
  parameter  int unsigned DEST_LSB = 40,
  parameter  int unsigned DEST_W   = 8,
  localparam int unsigned PKT_W    = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              pkt_req,
  input  logic              pkt_ack,
  output logic              pkt_token,
  output logic [DEST_W-1:0] pkt_dest,
  output logic [PKT_W-1:0]  pkt_data
);
  import bpb_pkg::*;

  localparam int unsigned CW = cnt_width(BYTES);

  ig_state_e        state_q, state_d;
  logic [PKT_W-1:0] acc_q, acc_d;
  logic [PKT_W-1:0] pkt_q;
  logic [PKT_W-1:0] acc_shift;
  logic             take;
  logic             last_byte;
  logic             acc_en;
  logic             pkt_en;
  logic [CW-1:0]    beat;

  assign take = in_valid && (state_q == IG_FILL);

  bpb_beat_counter #(.COUNT(BYTES)) u_beats (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (take),
    .cnt    (beat),
    .at_last(last_byte)
  );

  // shift left by one byte and fill the low byte with the new one
  assign acc_shift = {acc_q[PKT_W-9:0], in_data};

  always_comb begin
    state_d = state_q;
    acc_d   = acc_shift;
    acc_en  = 1'b0;
    pkt_en  = 1'b0;
    unique case (state_q)
      IG_FILL: begin
        if (take) begin
          acc_en = 1'b1;
          if (last_byte) begin
            pkt_en  = 1'b1;
            acc_d   = '0;
            state_d = IG_REQ;
          end
        end
      end
      IG_REQ:  if (pkt_ack)  state_d = IG_DROP;
      IG_DROP: if (!pkt_ack) state_d = IG_FILL;
      default: state_d = IG_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= IG_FILL;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pkt_q <= '0;
    else if (pkt_en) pkt_q <= acc_shift;
  end

  assign in_ready  = (state_q == IG_FILL);
  assign pkt_req   = (state_q == IG_REQ);
  assign pkt_data  = pkt_q;
  assign pkt_dest  = pkt_q[DEST_LSB +: DEST_W];
  assign pkt_token = 1'b0;
endmodule

// File: rtl/bpb_egress.sv
`timescale 1ns/1ps
module bpb_egress #(
  parameter  int unsigned BYTES  = 6,
  localparam int unsigned WORD_W = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_req,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ack,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);
  import bpb_pkg::*;

  localparam int unsigned CW = cnt_width(BYTES);

  eg_state_e         state_q, state_d;
  logic              send;
  logic              last_byte;
  logic [CW-1:0]     beat;
  logic [WORD_W-1:0] shifted;

  assign out_valid = word_req && (state_q == EG_SEND);
  assign send      = out_valid && out_ready;

  bpb_beat_counter #(.COUNT(BYTES)) u_beats (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (send),
    .cnt    (beat),
    .at_last(last_byte)
  );

  assign shifted  = word_data >> {beat, 3'b000};
  assign out_data = shifted[7:0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      EG_SEND: if (send && last_byte) state_d = EG_HOLD;
      EG_HOLD: if (!word_req)         state_d = EG_SEND;
      default: state_d = EG_SEND;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= EG_SEND;
    else        state_q <= state_d;
  end

  assign word_ack = (state_q == EG_HOLD);
endmodule

// File: rtl/byte_packet_bridge.sv
`timescale 1ns/1ps
module byte_packet_bridge #(
  parameter  int unsigned BYTES_PER_PKT = 6,
  parameter  int unsigned DEST_LSB      = 40,
  parameter  int unsigned DEST_W        = 8,
  localparam int unsigned PKT_W         = BYTES_PER_PKT * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              pkt_req,
  input  logic              pkt_ack,
  output logic              pkt_token,
  output logic [DEST_W-1:0] pkt_dest,
  output logic [PKT_W-1:0]  pkt_data,
  input  logic              word_req,
  output logic              word_ack,
  input  logic [PKT_W-1:0]  word_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);
  logic core_rst_n;

  bpb_reset_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(core_rst_n)
  );

  bpb_ingress #(
    .BYTES   (BYTES_PER_PKT),
    .DEST_LSB(DEST_LSB),
    .DEST_W  (DEST_W)
  ) u_ingress (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .pkt_req  (pkt_req),
    .pkt_ack  (pkt_ack),
    .pkt_token(pkt_token),
    .pkt_dest (pkt_dest),
    .pkt_data (pkt_data)
  );

  bpb_egress #(.BYTES(BYTES_PER_PKT)) u_egress (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .word_req (word_req),
    .word_data(word_data),
    .word_ack (word_ack),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );
endmodule

// File: rtl/bpb_checker.sv
`timescale 1ns/1ps
module bpb_checker #(
  parameter int unsigned PKT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             pkt_req,
  input logic             pkt_ack,
  input logic [PKT_W-1:0] pkt_data,
  input logic             word_req,
  input logic             word_ack,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data
);
  a_r3_req_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_req) |-> $past(in_valid && in_ready));

  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_req && !pkt_ack) |=> pkt_req);

  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_req && pkt_ack) |=> !pkt_req);

  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req |=> (!pkt_req || $stable(pkt_data)));

  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req |-> !in_ready);

  a_r8_no_valid_when_acked: assert property (@(posedge clk) disable iff (!rst_n)
    word_ack |-> !out_valid);

  a_r8_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ack && word_req) |=> word_ack);

  a_r8_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ack && !word_req) |=> !word_ack);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !word_ack) |=> (!word_req || (out_valid && $stable(out_data))));
endmodule

bind byte_packet_bridge bpb_checker #(.PKT_W(PKT_W)) u_bpb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .pkt_req  (pkt_req),
  .pkt_ack  (pkt_ack),
  .pkt_data (pkt_data),
  .word_req (word_req),
  .word_ack (word_ack),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/byte_packet_bridge_test.sv
`timescale 1ns/1ps
module byte_packet_bridge_test;
  localparam int unsigned NB = 6;
  localparam int unsigned W  = NB * 8;

  localparam logic [W-1:0] VECS [4] = '{
    48'hA1B2_C3D4_E5F6,
    48'h0102_0304_0506,
    48'hFF00_FF00_FF00,
    48'h7E5A_3C96_0F81
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, pkt_ack, word_req, out_ready;
  logic [7:0]   in_data;
  logic [W-1:0] word_data;
  logic         in_ready, pkt_req, pkt_token, word_ack, out_valid;
  logic [7:0]   pkt_dest, out_data;
  logic [W-1:0] pkt_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  byte_packet_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pkt_req(pkt_req), .pkt_ack(pkt_ack), .pkt_token(pkt_token),
    .pkt_dest(pkt_dest), .pkt_data(pkt_data),
    .word_req(word_req), .word_ack(word_ack), .word_data(word_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // sends a word most-significant byte first; returns one cycle after the last accept
  task automatic send_packet(input logic [W-1:0] w);
    for (int i = 0; i < NB; i++) begin
      send_byte(w[8*(NB-1-i) +: 8]);
      if (i == NB - 2)
        chk(pkt_req === 1'b0, "R3/R6 request early", 64'(pkt_req), 64'd0);
    end
    chk(pkt_req === 1'b1, "R3 request raised", 64'(pkt_req), 64'd1);
    chk(in_ready === 1'b0, "R3 in_ready dropped", 64'(in_ready), 64'd0);
    chk(pkt_data === w, "R2 packet word", 64'(pkt_data), 64'(w));
    chk(pkt_dest === w[47:40], "R4 destination field", 64'(pkt_dest), 64'(w[47:40]));
    chk(pkt_token === 1'b0, "R4 token clear", 64'(pkt_token), 64'd0);
  endtask

  task automatic ack_packet(input logic [W-1:0] w);
    @(negedge clk);
    chk(pkt_req === 1'b1 && pkt_data === w, "R5 held before ack", 64'(pkt_data), 64'(w));
    pkt_ack = 1'b1;
    @(negedge clk);
    chk(pkt_req === 1'b0, "R5 request falls after ack", 64'(pkt_req), 64'd0);
    chk(in_ready === 1'b0, "R5 ready waits for ack low", 64'(in_ready), 64'd0);
    pkt_ack = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1, "R5 ready returns", 64'(in_ready), 64'd1);
  endtask

  // called at a negedge; stall_at selects a byte index where out_ready is held low
  task automatic recv_word(input logic [W-1:0] w, input int stall_at);
    word_data = w;
    word_req  = 1'b1;
    out_ready = 1'b1;
    for (int k = 0; k < NB; k++) begin
      if (k == stall_at) begin
        out_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
          #1;
          chk(out_valid === 1'b1 && out_data === w[8*k +: 8], "R9 stalled byte held",
              64'(out_data), 64'(w[8*k +: 8]));
          @(negedge clk);
        end
        out_ready = 1'b1;
      end
      #1;
      chk(out_valid === 1'b1, "R7 byte offered", 64'(out_valid), 64'd1);
      chk(out_data === w[8*k +: 8], (k == 0) ? "R10 first byte of word" : "R7 byte order",
          64'(out_data), 64'(w[8*k +: 8]));
      @(negedge clk);
    end
    chk(word_ack === 1'b1, "R8 ack after last byte", 64'(word_ack), 64'd1);
    chk(out_valid === 1'b0, "R8 no byte while acked", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk(word_ack === 1'b1, "R8 ack holds while request high", 64'(word_ack), 64'd1);
    word_req = 1'b0;
    @(negedge clk);
    chk(word_ack === 1'b0, "R8 ack falls after request low", 64'(word_ack), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; pkt_ack = 1'b0;
    word_req = 1'b0; word_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && pkt_req === 1'b0, "R1 state in reset", 64'(pkt_req), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
    chk(pkt_req === 1'b0 && word_ack === 1'b0 && out_valid === 1'b0, "R1 handshakes idle",
        64'({pkt_req, word_ack, out_valid}), 64'd0);
    chk(pkt_data === '0, "R1 packet cleared", 64'(pkt_data), 64'd0);

    // table walk: each vector goes in as bytes and out as a word
    foreach (VECS[v]) begin
      send_packet(VECS[v]);
      ack_packet(VECS[v]);
      recv_word(VECS[v], -1);
    end

    // bytes offered while a packet waits for its acknowledge are refused
    send_packet(48'h1122_3344_5566);
    in_valid = 1'b1;
    in_data  = 8'hEE;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R6 busy refuses bytes", 64'(in_ready), 64'd0);
    end
    in_valid = 1'b0;
    ack_packet(48'h1122_3344_5566);
    send_packet(48'h99AA_BBCC_DDEE);
    ack_packet(48'h99AA_BBCC_DDEE);

    // consumer stall in the middle of a word
    @(negedge clk);
    recv_word(48'h0F1E_2D3C_4B5A, 2);
    @(negedge clk);
    recv_word(48'hC0DE_F00D_BEEF, 0);

    // reset in the middle of a packet handshake
    send_packet(48'h5555_AAAA_1234);
    rst_n = 1'b0;
    #1;
    chk(pkt_req === 1'b0 && in_ready === 1'b1, "R1 asynchronous reset",
        64'({pkt_req, in_ready}), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_packet(48'h0000_0000_00FF);
    ack_packet(48'h0000_0000_00FF);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule